// File: doc/BRIEF.md
# Program Counter Sequencer with Hardware Return Stack

This block holds the 16-bit program counter of a small microcontroller core and picks its next value on every fetch advance. The counter steps by one, loads a branch target, calls a subroutine (saving the return address on a hardware stack), returns by popping that stack, or jumps to a fixed vector when an interrupt is taken. The return stack is 16 entries deep, one PC wide, and is shared by calls, plain returns, returns with a literal and returns from interrupt.

Four interrupt request lines map to four vectors spaced eight words apart, starting at 0008h. While an interrupt is being serviced, new requests are held off until a return-from-interrupt clears the in-service flag. Overflow and underflow of the return stack are reported by sticky flags that only reset clears. Instruction decoding, interrupt enables and program memory are outside this block. The decoder drives an operation code and a target address together with a fetch-advance strobe.

Top module: `pc_sequencer`

## Requirements
- R1: Synchronous active-high reset sets the PC to 0000h, clears both stack flags and the in-service flag, and empties the return stack.
- R2: While `adv` is low, the PC, the stack, the stack flags and the in-service flag keep their values, whatever `op`, `target` and `irq` carry.
- R3: On an advance with `op` = 0 (and with codes 5 to 7, which act the same) and no interrupt taken, the PC becomes PC+1 modulo 2^16, so FFFFh is followed by 0000h.
- R4: On an advance with `op` = 1 (jump), the PC loads `target` and the stack is left alone.
- R5: On an advance with `op` = 2 (call), PC+1 is pushed and the PC loads `target`.
- R6: On an advance with `op` = 3 (return, with or without a literal), the top entry is popped into the PC.
- R7: On an advance with `op` = 4 (return from interrupt), the top entry is popped into the PC and the in-service flag is cleared.
- R8: On an advance with any `irq` bit set and the in-service flag low, PC+1 is pushed, the PC loads the vector (bit 0 gives 0008h, bit 1 gives 0010h, bit 2 gives 0018h, bit 3 gives 0020h), the in-service flag is set, and `op` is ignored for that advance.
- R9: When several `irq` bits are set together, the lowest-numbered bit, which has the lowest vector, wins.
- R10: While the in-service flag is set, `irq` has no effect and `op` is carried out as usual.
- R11: A push with 16 entries already held sets the sticky `stk_ovf` flag and discards the oldest entry, so the 16 newest return addresses remain.
- R12: A pop from an empty stack sets the sticky `stk_unf` flag and loads the PC with 0000h.
- R13: Sixteen nested pushes followed by sixteen pops return the saved addresses in reverse order with neither flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Fetch advance; the PC updates only when high |
| op | input | 3 | Operation: 0 step, 1 jump, 2 call, 3 return, 4 return from interrupt |
| target | input | 16 | Jump or call destination |
| irq | input | 4 | Interrupt requests, bit 0 highest priority |
| pc | output | 16 | Current program counter |
| stk_ovf | output | 1 | Sticky return-stack overflow |
| stk_unf | output | 1 | Sticky return-stack underflow |
| in_irq | output | 1 | Interrupt in service |

## Verification
Straight-line stepping, with a jump to FFFFh, separates correct modulo wrap from a stuck or saturating counter. Single call/return pairs and sixteen-deep nesting show the stack order and its depth. Single and combined interrupt requests, raised both outside and inside service, tell priority apart from in-service masking. Seventeen pushes followed by seventeen pops tell oldest-entry discard apart from newest-entry loss and show the underflow reload to 0000h. A long stretch of mixed operations, compared on every clock against a queue-based model, covers the interleavings that the directed cases miss.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int PC_W       = 16;
    localparam int STK_DEPTH  = 16;
    localparam int N_IRQ      = 4;
    localparam int OP_W       = 3;
    localparam int VEC_BASE   = 8;
    localparam int VEC_STRIDE = 8;

    typedef logic [PC_W-1:0] pc_t;

    typedef enum logic [OP_W-1:0] {
        OP_STEP = 3'd0,
        OP_JUMP = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_RETI = 3'd4
    } op_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic set_svc;
        logic clr_svc;
    } seq_ctl_t;

    function automatic pc_t vector_of(input int idx);
        return pc_t'(VEC_BASE + idx * VEC_STRIDE);
    endfunction

endpackage

// File: rtl/pcs_irq_arb.sv
module pcs_irq_arb
    import pcs_pkg::*;
#(
    parameter int NREQ = N_IRQ,
    parameter int AW   = PC_W
) (
    input  logic [NREQ-1:0] req,
    input  logic            block,
    output logic            take,
    output logic [AW-1:0]   vec_addr
);
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;

    logic [IW-1:0] win_idx;
    logic [AW-1:0] vec_tbl [NREQ];

    generate
        for (genvar g = 0; g < NREQ; g++) begin : g_vec
            assign vec_tbl[g] = AW'(VEC_BASE + g * VEC_STRIDE);
        end
    endgenerate

    // Scan from the highest index down so the lowest set bit is left last.
    always_comb begin
        win_idx = '0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (req[i]) win_idx = IW'(i);
        end
    end

    assign take     = (|req) && !block;
    assign vec_addr = vec_tbl[win_idx];

endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
    parameter int DEPTH = 16,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_data,
    output logic         ovf,
    output logic         unf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rd_idx;
    logic [CW-1:0] used;
    logic          full;
    logic          empty;

    assign full   = (used == CW'(DEPTH));
    assign empty  = (used == '0);
    assign rd_idx = wptr - AW'(1);

    // Empty pop reads as zero so the PC falls back to the reset vector.
    assign top_data = empty ? '0 : mem[rd_idx];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            used <= '0;
            ovf  <= 1'b0;
            unf  <= 1'b0;
        end else if (push) begin
            wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
            if (full) begin
                ovf <= 1'b1;
            end else begin
                used <= used + CW'(1);
            end
        end else if (pop) begin
            if (empty) begin
                unf <= 1'b1;
            end else begin
                wptr <= (wptr == '0) ? AW'(DEPTH - 1) : rd_idx;
                used <= used - CW'(1);
            end
        end
    end

endmodule

// File: rtl/pcs_next_pc.sv
module pcs_next_pc
    import pcs_pkg::*;
(
    input  logic            adv,
    input  logic [OP_W-1:0] op,
    input  pc_t             pc,
    input  pc_t             target,
    input  logic            take_irq,
    input  pc_t             vec_addr,
    input  pc_t             pop_data,
    output pc_t             next_pc,
    output pc_t             ret_addr,
    output seq_ctl_t        ctl
);
    op_e op_dec;

    assign op_dec   = op_e'(op);
    assign ret_addr = pc + pc_t'(1);

    always_comb begin
        ctl     = '0;
        next_pc = pc;
        if (adv) begin
            if (take_irq) begin
                ctl.push    = 1'b1;
                ctl.set_svc = 1'b1;
                next_pc     = vec_addr;
            end else begin
                unique case (op_dec)
                    OP_JUMP: next_pc = target;
                    OP_CALL: begin
                        ctl.push = 1'b1;
                        next_pc  = target;
                    end
                    OP_RET: begin
                        ctl.pop = 1'b1;
                        next_pc = pop_data;
                    end
                    OP_RETI: begin
                        ctl.pop     = 1'b1;
                        ctl.clr_svc = 1'b1;
                        next_pc     = pop_data;
                    end
                    default: next_pc = ret_addr;
                endcase
            end
        end
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcs_pkg::*;
#(
    parameter int W     = PC_W,
    parameter int DEPTH = STK_DEPTH,
    parameter int NREQ  = N_IRQ
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    target,
    input  logic [NREQ-1:0] irq,
    output logic [W-1:0]    pc,
    output logic            stk_ovf,
    output logic            stk_unf,
    output logic            in_irq
);
    logic [W-1:0] pc_q;
    logic [W-1:0] next_pc;
    logic [W-1:0] ret_addr;
    logic [W-1:0] vec_addr;
    logic [W-1:0] pop_data;
    logic         svc_q;
    logic         take_irq;
    seq_ctl_t     ctl;

    pcs_irq_arb #(.NREQ(NREQ), .AW(W)) u_arb (
        .req      (irq),
        .block    (svc_q),
        .take     (take_irq),
        .vec_addr (vec_addr)
    );

    pcs_next_pc u_next (
        .adv      (adv),
        .op       (op),
        .pc       (pc_q),
        .target   (target),
        .take_irq (take_irq),
        .vec_addr (vec_addr),
        .pop_data (pop_data),
        .next_pc  (next_pc),
        .ret_addr (ret_addr),
        .ctl      (ctl)
    );

    pcs_ret_stack #(.DEPTH(DEPTH), .W(W)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (ctl.push),
        .pop       (ctl.pop),
        .push_data (ret_addr),
        .top_data  (pop_data),
        .ovf       (stk_ovf),
        .unf       (stk_unf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            svc_q <= 1'b0;
        end else begin
            pc_q <= next_pc;
            if (ctl.set_svc) begin
                svc_q <= 1'b1;
            end else if (ctl.clr_svc) begin
                svc_q <= 1'b0;
            end
        end
    end

    assign pc     = pc_q;
    assign in_irq = svc_q;

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker (
    input logic        clk,
    input logic        rst,
    input logic        adv,
    input logic [2:0]  op,
    input logic [3:0]  irq,
    input logic [15:0] pc,
    input logic        stk_ovf,
    input logic        stk_unf,
    input logic        in_irq
);
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (pc == 16'h0000 && !stk_ovf && !stk_unf && !in_irq)); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(pc) && $stable(in_irq) && $stable(stk_ovf) && $stable(stk_unf))); // R2

    AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
        (adv && op == 3'd0 && (irq == 4'd0 || in_irq)) |=> (pc == $past(pc) + 16'd1)); // R3

    AST_VECTOR_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (adv && irq != 4'd0 && !in_irq) |=>
            (in_irq && (pc == 16'h0008 || pc == 16'h0010 || pc == 16'h0018 || pc == 16'h0020))); // R8

    AST_TOP_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (adv && irq[0] && !in_irq) |=> (pc == 16'h0008)); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        stk_ovf |=> stk_ovf); // R11

    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
        stk_unf |=> stk_unf); // R12

    AST_SVC_HELD: assert property (@(posedge clk) disable iff (rst)
        (in_irq && !(adv && op == 3'd4)) |=> in_irq); // R10

endmodule

bind pc_sequencer pcs_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .op      (op),
    .irq     (irq),
    .pc      (pc),
    .stk_ovf (stk_ovf),
    .stk_unf (stk_unf),
    .in_irq  (in_irq)
);

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] target = 16'h0000;
    logic [3:0]  irq = 4'd0;
    logic [15:0] pc;
    logic        stk_ovf;
    logic        stk_unf;
    logic        in_irq;

    int compared = 0;
    int mismatched = 0;

    logic [15:0] m_pc = 16'h0000;
    logic        m_ovf = 1'b0;
    logic        m_unf = 1'b0;
    logic        m_svc = 1'b0;
    logic [15:0] m_stk [$];

    always #4 clk = ~clk;

    pc_sequencer dut (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .op      (op),
        .target  (target),
        .irq     (irq),
        .pc      (pc),
        .stk_ovf (stk_ovf),
        .stk_unf (stk_unf),
        .in_irq  (in_irq)
    );

    function automatic void m_push(input logic [15:0] v);
        if (m_stk.size() == 16) begin
            m_ovf = 1'b1;
            void'(m_stk.pop_front());
        end
        m_stk.push_back(v);
    endfunction

    function automatic logic [15:0] m_pop();
        if (m_stk.size() == 0) begin
            m_unf = 1'b1;
            return 16'h0000;
        end
        return m_stk.pop_back();
    endfunction

    function automatic void model_tick();
        if (rst) begin
            m_pc = 16'h0000;
            m_ovf = 1'b0;
            m_unf = 1'b0;
            m_svc = 1'b0;
            m_stk.delete();
        end else if (adv) begin
            if (irq != 4'd0 && !m_svc) begin
                m_push(m_pc + 16'd1);
                m_svc = 1'b1;
                if (irq[0]) m_pc = 16'h0008;
                else if (irq[1]) m_pc = 16'h0010;
                else if (irq[2]) m_pc = 16'h0018;
                else m_pc = 16'h0020;
            end else begin
                case (op)
                    3'd1: m_pc = target;
                    3'd2: begin m_push(m_pc + 16'd1); m_pc = target; end
                    3'd3: m_pc = m_pop();
                    3'd4: begin m_pc = m_pop(); m_svc = 1'b0; end
                    default: m_pc = m_pc + 16'd1;
                endcase
            end
        end
    endfunction

    task automatic compare(input string tag);
        compared++;
        if (pc !== m_pc || stk_ovf !== m_ovf || stk_unf !== m_unf || in_irq !== m_svc) begin
            mismatched++;
            $display("FAIL %s: pc=%h ovf=%b unf=%b svc=%b expected pc=%h ovf=%b unf=%b svc=%b",
                     tag, pc, stk_ovf, stk_unf, in_irq, m_pc, m_ovf, m_unf, m_svc);
        end
    endtask

    task automatic step(input logic a, input logic [2:0] o, input logic [15:0] t,
                        input logic [3:0] q, input string tag);
        @(negedge clk);
        adv = a; op = o; target = t; irq = q;
        @(posedge clk);
        #1;
        model_tick();
        compare(tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1; adv = 1'b1; op = 3'd2; irq = 4'hF;
        @(posedge clk);
        #1;
        model_tick();
        @(negedge clk);
        rst = 1'b0; adv = 1'b0; op = 3'd0; irq = 4'd0;
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        do_reset("R1 reset state");

        for (int i = 0; i < 5; i++) step(1'b1, 3'd0, 16'h0, 4'd0, "R3 step");
        step(1'b1, 3'd6, 16'h0, 4'd0, "R3 unused code steps");
        step(1'b1, 3'd1, 16'hFFFF, 4'd0, "R4 jump");
        step(1'b1, 3'd0, 16'h0, 4'd0, "R3 wrap to 0000h");
        step(1'b0, 3'd2, 16'h4444, 4'hF, "R2 idle ignores inputs");
        step(1'b0, 3'd3, 16'h0, 4'd0, "R2 idle ignores pop");

        step(1'b1, 3'd2, 16'h1234, 4'd0, "R5 call");
        step(1'b1, 3'd0, 16'h0, 4'd0, "R3 step in callee");
        step(1'b1, 3'd3, 16'h0, 4'd0, "R6 return");

        step(1'b1, 3'd1, 16'h0400, 4'b1100, "R9 bit 2 beats bit 3");
        step(1'b1, 3'd0, 16'h0, 4'b0001, "R10 masked while in service");
        step(1'b1, 3'd2, 16'h0700, 4'b0011, "R10 call runs while in service");
        step(1'b1, 3'd3, 16'h0, 4'd0, "R6 return inside service");
        step(1'b1, 3'd4, 16'h0, 4'd0, "R7 return from interrupt");
        for (int b = 0; b < 4; b++) begin
            step(1'b1, 3'd1, 16'h2000, 4'(1 << b), "R8 single source vector");
            step(1'b1, 3'd4, 16'h0, 4'd0, "R7 leave service");
        end
        step(1'b1, 3'd2, 16'h3000, 4'b1111, "R9 all pending, bit 0 wins");
        step(1'b1, 3'd4, 16'h0, 4'd0, "R7 leave service");

        for (int i = 0; i < 16; i++) step(1'b1, 3'd2, 16'(16'h5000 + i * 16), 4'd0, "R13 nested call");
        for (int i = 0; i < 16; i++) step(1'b1, 3'd3, 16'h0, 4'd0, "R13 nested return");

        do_reset("R1 reset before overflow");
        for (int i = 0; i < 17; i++) step(1'b1, 3'd2, 16'(16'h6000 + i * 4), 4'd0, "R11 push past depth");
        for (int i = 0; i < 16; i++) step(1'b1, 3'd3, 16'h0, 4'd0, "R11 newest entries kept");
        step(1'b1, 3'd3, 16'h0, 4'd0, "R12 pop from empty");
        step(1'b1, 3'd0, 16'h0, 4'd0, "R12 flag sticky");
        do_reset("R1 reset clears flags");
        step(1'b1, 3'd4, 16'h0, 4'd0, "R12 empty return from interrupt");

        do_reset("R1 reset before mixed run");
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic [2:0] o;
            logic [3:0] q;
            r = int'($urandom_range(0, 99));
            if (r < 40) o = 3'd0;
            else if (r < 52) o = 3'd1;
            else if (r < 70) o = 3'd2;
            else if (r < 85) o = 3'd3;
            else if (r < 95) o = 3'd4;
            else o = 3'(5 + $urandom_range(0, 2));
            q = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(1, 15)) : 4'd0;
            step(1'($urandom_range(0, 7) != 0), o, 16'($urandom), q, "R8 mixed run");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule